// File: doc/BRIEF.md
# Clocked Serial Port with Receive Buffer

This block is an 8-bit synchronous serial port. It can drive the serial clock itself (master) or follow a clock from another device (slave). A small register interface sets the mode. In master mode the host starts a byte transfer simply by reading or writing the shift register.

Each completed byte is copied into a receive buffer that has a valid flag. A one-cycle interrupt pulse marks the completion of the byte. If a byte lands while the buffer still holds unread data, a sticky overflow flag is raised.

The block has output enables for the clock pin and the data-out pin. The host uses them to hand the pins back to general port use when the port is disabled. The data-out enable is also dropped in receive-only mode.

Top module: `csi_port`

Register map (`reg_sel`):
- 0: control. Bit 0 is the enable. Bit 1 is receive-only. Bits 3:2 are the clock select.
- 1: shift register.
- 2: receive buffer. Reading it clears the valid flag.
- 3: status. Bit 0 is valid, bit 1 is overflow, bit 2 is busy. Writing 1 to bit 1 clears overflow.

## Requirements
- R1: After reset, `sck_out` is 1, both output enables are 0, `irq` is 0 and the status register reads 0.
- R2: A clock-select value of 00 selects slave mode, with `sck_oe` = 0. The values 01, 10 and 11 select master mode, with `sck_oe` equal to the enable bit.
- R3: In master mode, a write to the shift register (`reg_sel` = 1) sends that byte MSB first as 8 rising clock edges. `sdo_out` changes only while `sck_out` is low. The clock idles high. The bit sampled from `sdi_in` at each rising edge forms the received byte, MSB first.
- R4: In master mode, a read of the shift register also starts a transfer, which sends the current contents.
- R5: In master mode, each half period of `sck_out` lasts 2, 4 or 8 system cycles for clock select 01, 10 or 11 (the system clock divided by 4, 8 or 16).
- R6: In slave mode, bits are taken from `sdi_in` on the synchronized rising edges of `sck_in`. After the eighth edge, the byte is placed in the receive buffer and valid becomes 1.
- R7: `irq` is high for exactly one cycle per completed byte.
- R8: A read of the receive buffer (`reg_sel` = 2) returns the last byte and clears valid.
- R9: When a byte completes while valid is 1 and the buffer is not being read, overflow is set. It stays set until the status register is written with bit 1 = 1.
- R10: A read or write of the shift register during a transfer is ignored. The transfer is neither restarted nor altered.
- R11: `sdo_oe` is 0 in receive-only mode (control bit 1 = 1). Otherwise it equals the enable bit, in both master and slave mode.
- R12: With the enable bit at 0, both output enables are 0, and shift register accesses start no transfer.
- R13: In slave mode, `sdo_out` presents the loaded byte MSB first and advances after the falling edges of `sck_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| sck_in | input | 1 | Serial clock from the pin (slave mode) |
| sck_out | output | 1 | Serial clock to the pin (master mode) |
| sck_oe | output | 1 | Serial clock output enable |
| sdi_in | input | 1 | Serial data input |
| sdo_out | output | 1 | Serial data output |
| sdo_oe | output | 1 | Serial data output enable |
| irq | output | 1 | Byte completion pulse |

## Verification
Master transfers are run at all three clock rates, with different outgoing and incoming bytes. Counting the low clock cycles separates the three dividers. Distinct patterns in each direction expose bit order and bit loss. One transfer is started by a read rather than a write, which shows that the received byte is sent back out. Another is disturbed by accesses in mid-flight, which separates an ignored access from a restart. A slave exchange driven by a slow external clock checks the synchronizer, the edge phases and the data-out shifting. Leaving the buffer unread across two bytes, and then clearing the flag, exercises overflow and its stickiness.

// File: rtl/csi_pkg.sv
package csi_pkg;
    localparam int DATA_W = 8;
    localparam int HALF_W = 4;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_SHIFT = 2'd1,
        REG_RXBUF = 2'd2,
        REG_STAT  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [1:0] clk_sel;
        logic       rx_only;
        logic       en;
    } ctrl_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } clk_ev_t;

    // half period in system cycles: 01 -> 2, 10 -> 4, 11 -> 8
    function automatic logic [HALF_W-1:0] half_period(input logic [1:0] sel);
        return HALF_W'(1) << sel;
    endfunction

    function automatic logic is_master(input logic [1:0] sel);
        return sel != 2'b00;
    endfunction
endpackage

// File: rtl/csi_clkgen.sv
module csi_clkgen
    import csi_pkg::*;
#(
    parameter int HW = HALF_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       master,
    input  logic [1:0] clk_sel,
    input  logic       start,
    input  logic       active,
    input  logic       sck_in,
    input  logic       sdi_in,
    output logic       sck_out,
    output clk_ev_t    ev,
    output logic       sdi_bit
);
    logic [HW-1:0] cnt;
    logic [HW-1:0] half;
    logic          sck_q;
    logic          tick;
    logic [2:0]    sck_sync;
    logic [1:0]    sdi_sync;

    assign half    = half_period(clk_sel);
    assign tick    = active && (cnt == half - HW'(1));
    assign sck_out = sck_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            sck_q <= 1'b1;
        end else if (!en || !master) begin
            cnt   <= '0;
            sck_q <= 1'b1;
        end else if (start) begin
            cnt   <= '0;
            sck_q <= 1'b0;
        end else if (active) begin
            if (tick) begin
                cnt   <= '0;
                sck_q <= ~sck_q;
            end else begin
                cnt <= cnt + HW'(1);
            end
        end else begin
            cnt   <= '0;
            sck_q <= 1'b1;
        end
    end

    // external clock and data share the same synchronizer depth
    always_ff @(posedge clk) begin
        if (rst) begin
            sck_sync <= 3'b111;
            sdi_sync <= 2'b00;
        end else begin
            sck_sync <= {sck_sync[1:0], sck_in};
            sdi_sync <= {sdi_sync[0], sdi_in};
        end
    end

    always_comb begin
        if (master) begin
            ev.rise = tick && !sck_q;
            ev.fall = tick && sck_q;
            sdi_bit = sdi_in;
        end else begin
            ev.rise = en && sck_sync[1] && !sck_sync[2];
            ev.fall = en && !sck_sync[1] && sck_sync[2];
            sdi_bit = sdi_sync[1];
        end
    end

    // R3: clock returns to and stays at its high idle level
    p_idle_high_r3: assert property (@(posedge clk) disable iff (rst)
        (en && master && !active && !start) |=> sck_out);
endmodule

// File: rtl/csi_shifter.sv
module csi_shifter
    import csi_pkg::*;
#(
    parameter int DW = DATA_W,
    localparam int CW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          master,
    input  logic          start,
    input  logic          load,
    input  logic [DW-1:0] wdata,
    input  clk_ev_t       ev,
    input  logic          sdi_bit,
    output logic [DW-1:0] shreg,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rx_byte
);
    logic [CW-1:0] cnt;
    logic          pend;
    logic          rx_bit;
    logic          busy_q;
    logic          last;

    assign last    = (cnt == CW'(DW - 1));
    assign done    = en && ev.rise && last;
    assign rx_byte = {shreg[DW-2:0], sdi_bit};
    assign busy    = master ? busy_q : ((cnt != '0) || pend);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            cnt    <= '0;
            pend   <= 1'b0;
            rx_bit <= 1'b0;
            busy_q <= 1'b0;
        end else if (!en) begin
            cnt    <= '0;
            pend   <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            if (load) shreg <= wdata;
            if (start) begin
                busy_q <= 1'b1;
                cnt    <= '0;
                pend   <= 1'b0;
            end else if (ev.rise) begin
                if (last) begin
                    shreg  <= rx_byte;
                    cnt    <= '0;
                    pend   <= 1'b0;
                    busy_q <= 1'b0;
                end else begin
                    rx_bit <= sdi_bit;
                    pend   <= 1'b1;
                    cnt    <= cnt + CW'(1);
                end
            end else if (ev.fall && pend) begin
                shreg <= {shreg[DW-2:0], rx_bit};
                pend  <= 1'b0;
            end
        end
    end

    // R10: a running master transfer never restarts
    p_no_restart_r10: assert property (@(posedge clk) disable iff (rst)
        (en && master && busy_q && !done) |=> (busy_q && cnt >= $past(cnt)));
    // R3: output bit holds across a non-final rising edge
    p_msb_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (en && ev.rise && !last && !load) |=> (shreg[DW-1] == $past(shreg[DW-1])));
    // R12: disabled port is idle
    p_off_idle_r12: assert property (@(posedge clk) disable iff (rst)
        !en |=> !busy);
endmodule

// File: rtl/csi_rxbuf.sv
module csi_rxbuf
    import csi_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          done,
    input  logic [DW-1:0] rx_byte,
    input  logic          rd_buf,
    input  logic          clr_ovf,
    output logic [DW-1:0] buf_q,
    output logic          valid,
    output logic          ovf,
    output logic          irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= '0;
            valid <= 1'b0;
            ovf   <= 1'b0;
            irq   <= 1'b0;
        end else begin
            irq <= done;
            if (done) begin
                buf_q <= rx_byte;
                valid <= 1'b1;
            end else if (rd_buf) begin
                valid <= 1'b0;
            end
            if (done && valid && !rd_buf) ovf <= 1'b1;
            else if (clr_ovf)             ovf <= 1'b0;
        end
    end

    p_irq_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);
    p_valid_set_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> (valid && irq));
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clr_ovf) |=> ovf);
    p_ovf_cause_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> $past(done && valid));
endmodule

// File: rtl/csi_port.sv
module csi_port
    import csi_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    reg_sel,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          sck_in,
    output logic          sck_out,
    output logic          sck_oe,
    input  logic          sdi_in,
    output logic          sdo_out,
    output logic          sdo_oe,
    output logic          irq
);
    localparam int CTRL_W = $bits(ctrl_t);

    ctrl_t         ctrl;
    reg_sel_e      sel;
    logic          master;
    logic          busy, done, start, load, rd_buf, clr_ovf, shift_acc;
    logic          sdi_bit, valid, ovf;
    logic [DW-1:0] shreg, rx_byte, buf_q;
    clk_ev_t       ev;

    assign sel       = reg_sel_e'(reg_sel);
    assign master    = is_master(ctrl.clk_sel);
    assign shift_acc = (reg_wr || reg_rd) && (sel == REG_SHIFT);
    assign start     = shift_acc && ctrl.en && master && !busy;
    assign load      = reg_wr && (sel == REG_SHIFT) && ctrl.en && !busy;
    assign rd_buf    = reg_rd && (sel == REG_RXBUF);
    assign clr_ovf   = reg_wr && (sel == REG_STAT) && reg_wdata[1];

    always_ff @(posedge clk) begin
        if (rst) ctrl <= '0;
        else if (reg_wr && sel == REG_CTRL) ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end

    always_comb begin
        unique case (sel)
            REG_CTRL:  reg_rdata = DW'(ctrl);
            REG_SHIFT: reg_rdata = shreg;
            REG_RXBUF: reg_rdata = buf_q;
            default:   reg_rdata = DW'({busy, ovf, valid});
        endcase
    end

    assign sck_oe  = ctrl.en && master;
    assign sdo_oe  = ctrl.en && !ctrl.rx_only;
    assign sdo_out = shreg[DW-1];

    csi_clkgen u_clk (
        .clk(clk), .rst(rst), .en(ctrl.en), .master(master),
        .clk_sel(ctrl.clk_sel), .start(start), .active(busy && master),
        .sck_in(sck_in), .sdi_in(sdi_in), .sck_out(sck_out),
        .ev(ev), .sdi_bit(sdi_bit)
    );

    csi_shifter #(.DW(DW)) u_shf (
        .clk(clk), .rst(rst), .en(ctrl.en), .master(master),
        .start(start), .load(load), .wdata(reg_wdata), .ev(ev),
        .sdi_bit(sdi_bit), .shreg(shreg), .busy(busy), .done(done),
        .rx_byte(rx_byte)
    );

    csi_rxbuf #(.DW(DW)) u_rxb (
        .clk(clk), .rst(rst), .done(done), .rx_byte(rx_byte),
        .rd_buf(rd_buf), .clr_ovf(clr_ovf), .buf_q(buf_q),
        .valid(valid), .ovf(ovf), .irq(irq)
    );
endmodule

// File: tb/csi_port_test.sv
`timescale 1ns/1ps
module csi_port_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] reg_sel = 2'd0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00, reg_rdata;
    logic       sck_in = 1'b1, sck_out, sck_oe;
    logic       sdi_in, sdo_out, sdo_oe, irq;

    logic       slv_mode = 1'b0;
    logic       sdi_drv = 1'b0;
    logic [7:0] slave_byte = 8'h00;
    logic [2:0] bitn = 3'd0;

    int n_chk = 0, n_bad = 0;
    int lowcnt = 0, irq_cnt = 0;
    logic mon_en = 1'b0;
    logic prev_sck = 1'b1, last_low = 1'b0;
    logic [7:0] cap = 8'h00;
    int capn = 0;
    logic [7:0] exp_q[$];

    assign sdi_in = slv_mode ? sdi_drv : slave_byte[3'd7 - bitn];

    always #2.5 clk = ~clk;

    csi_port uut (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_in(sck_in),
        .sck_out(sck_out), .sck_oe(sck_oe), .sdi_in(sdi_in), .sdo_out(sdo_out),
        .sdo_oe(sdo_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (exp_q.size() != 0) chk("R3 pending scoreboard items", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // monitor: counts low cycles, drives the model slave, scores master output
    always @(negedge clk) begin
        if (irq) irq_cnt++;
        if (mon_en) begin
            if (sck_out == 1'b0) lowcnt++;
            if (prev_sck == 1'b0 && sck_out == 1'b1) begin
                cap = {cap[6:0], last_low};
                capn++;
                bitn = bitn + 3'd1;
                if (capn == 8) begin
                    capn = 0;
                    if (exp_q.size() == 0) chk("R3 unexpected master byte", cap, 8'hxx);
                    else chk("R3 master sdo byte", cap, exp_q.pop_front());
                end
            end
            if (sck_out == 1'b0) last_low = sdo_out;
            prev_sck = sck_out;
        end
    end

    task automatic bus_wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] s, output logic [7:0] d);
        @(negedge clk);
        reg_sel = s; reg_rd = 1'b1;
        #0.1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_irq(input string req);
        int k = 0;
        while (!irq && k < 3000) begin
            @(negedge clk);
            k++;
        end
        chk({req, " irq seen"}, irq, 1'b1);
        @(negedge clk);
        chk("R7 irq single cycle", irq, 1'b0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        logic [7:0] rd, got;
        int irq0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        mon_en = 1'b1;
        // R1 reset state
        chk("R1 sck_out", sck_out, 1'b1);
        chk("R1 sck_oe", sck_oe, 1'b0);
        chk("R1 sdo_oe", sdo_oe, 1'b0);
        chk("R1 irq", irq, 1'b0);
        bus_rd(2'd3, rd); chk("R1 status", rd, 8'h00);

        // master, /4, write start
        bus_wr(2'd0, 8'h05);
        chk("R2 master sck_oe", sck_oe, 1'b1);
        chk("R11 txrx sdo_oe", sdo_oe, 1'b1);
        slave_byte = 8'h3C; lowcnt = 0;
        exp_q.push_back(8'hA5);
        bus_wr(2'd1, 8'hA5);
        wait_irq("R3");
        chk("R5 low cycles div4", lowcnt, 16);
        bus_rd(2'd3, rd); chk("R8 valid before read", rd, 8'h01);
        bus_rd(2'd2, rd); chk("R3 received byte", rd, 8'h3C);
        bus_rd(2'd3, rd); chk("R8 valid cleared", rd, 8'h00);

        // master, /8, read start sends the received byte back out
        bus_wr(2'd0, 8'h09);
        slave_byte = 8'h96; lowcnt = 0;
        exp_q.push_back(8'h3C);
        bus_rd(2'd1, rd);
        wait_irq("R4");
        chk("R5 low cycles div8", lowcnt, 32);
        bus_rd(2'd3, rd); chk("R9 valid no overflow", rd, 8'h01);

        // master, /16, with accesses mid-transfer and unread buffer
        bus_wr(2'd0, 8'h0D);
        slave_byte = 8'hC3; lowcnt = 0;
        exp_q.push_back(8'h5A);
        irq0 = irq_cnt;
        bus_wr(2'd1, 8'h5A);
        repeat (20) @(negedge clk);
        bus_wr(2'd1, 8'hFF);
        bus_rd(2'd1, rd);
        wait_irq("R10");
        chk("R10 low cycles not restarted", lowcnt, 64);
        repeat (10) @(negedge clk);
        chk("R10 single completion", irq_cnt - irq0, 1);
        bus_rd(2'd3, rd); chk("R9 overflow set", rd, 8'h03);
        bus_rd(2'd2, rd); chk("R9 newest byte kept", rd, 8'hC3);
        bus_rd(2'd3, rd); chk("R9 overflow sticky after read", rd, 8'h02);
        bus_wr(2'd3, 8'h02);
        bus_rd(2'd3, rd); chk("R9 overflow cleared", rd, 8'h00);

        // receive-only
        bus_wr(2'd0, 8'h07);
        chk("R11 rx_only sdo_oe", sdo_oe, 1'b0);
        chk("R2 rx_only sck_oe", sck_oe, 1'b1);

        // disabled
        bus_wr(2'd0, 8'h04);
        chk("R12 sck_oe off", sck_oe, 1'b0);
        chk("R12 sdo_oe off", sdo_oe, 1'b0);
        irq0 = irq_cnt; lowcnt = 0;
        bus_wr(2'd1, 8'h11);
        repeat (60) @(negedge clk);
        chk("R12 no clock activity", lowcnt, 0);
        chk("R12 no completion", irq_cnt - irq0, 0);

        // slave exchange
        bus_wr(2'd0, 8'h01);
        chk("R2 slave sck_oe", sck_oe, 1'b0);
        chk("R11 slave sdo_oe", sdo_oe, 1'b1);
        slv_mode = 1'b1;
        bus_wr(2'd1, 8'hE1);
        irq0 = irq_cnt; got = 8'h00;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            sck_in = 1'b0;
            sdi_drv = 8'h4B >> (7 - i);
            repeat (8) @(negedge clk);
            got = {got[6:0], sdo_out};
            sck_in = 1'b1;
            repeat (8) @(negedge clk);
        end
        chk("R13 slave sdo byte", got, 8'hE1);
        chk("R6 slave completion", irq_cnt - irq0, 1);
        chk("R2 slave sck_out idle", sck_out, 1'b1);
        bus_rd(2'd3, rd); chk("R6 slave valid", rd, 8'h01);
        bus_rd(2'd2, rd); chk("R6 slave received byte", rd, 8'h4B);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule